// File: doc/BRIEF.md
# Boot Image Copy Controller

This controller runs once after power-up in a system whose running address map holds only fast RAM and a single 256-byte I/O page, with no boot ROM mapped. It holds the main CPU in reset and keeps the system clock on its slow setting. It takes the boot image one byte at a time from a helper that reads a slow serial non-volatile store, over a ready/valid byte interface. Each byte is written into fast SRAM with an active-low write strobe, at consecutive addresses starting from a parameterised base near the top of the map.

When the last byte has been written, the controller moves the clock select to fast. After a parameterised settling time it releases the CPU reset, so the processor starts from an image that is already complete in RAM. If the source stops delivering for longer than a limit set at a port, the controller flags an error and keeps the CPU in reset until the next system reset.

Top module: `boot_copy_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it: `cpu_reset`=1, `clk_fast_sel`=0, `sram_we_n`=1, `src_ready`=0, `boot_error`=0. `src_ready` goes to 1 on the first clock edge with `rst` low.
- R2: A byte is taken on a rising edge where `src_ready` and `src_valid` are both 1. `src_ready` is 0 in the cycle that follows and returns to 1 one cycle later if bytes remain.
- R3: The k-th accepted byte (k from 0) is written with `sram_addr` = START_ADDR + k and `sram_wdata` equal to that byte.
- R4: Each write strobe is low for exactly one clock cycle, starting on the edge that accepts the byte. Address and data hold their values through the edge that ends the strobe.
- R5: Exactly IMAGE_LEN bytes are written. After that, `src_ready` stays 0 and further `src_valid` pulses produce no strobe.
- R6: `clk_fast_sel` goes high exactly two clock cycles after the final strobe goes low. It changes only in the clock-switch phase, and it stays high until `rst`.
- R7: `cpu_reset` falls exactly SETTLE_CYCLES cycles (at least two) after `clk_fast_sel` rises.
- R8: `cpu_reset` is 1 in every state other than the run state, including during the whole copy.
- R9: With a nonzero `stall_limit` of L, `boot_error` rises on the L-th consecutive edge where `src_ready`=1 and `src_valid`=0. After that, `src_ready`=0, no further writes occur, `cpu_reset` stays 1 and `clk_fast_sel` stays 0 until `rst`.
- R10: A `stall_limit` of 0 disables the timeout. Any run of waiting edges shorter than L raises no error, and the wait count restarts at every accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (slow setting during the copy) |
| rst | input | 1 | Synchronous active-high reset |
| stall_limit | input | STALL_W | Timeout in waiting cycles; 0 disables it |
| src_valid | input | 1 | Byte source has a byte |
| src_data | input | 8 | Byte from the source |
| src_ready | output | 1 | Controller can take a byte |
| sram_addr | output | ADDR_W | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we_n | output | 1 | Active-low SRAM write strobe |
| clk_fast_sel | output | 1 | 0 selects the slow clock, 1 the fast clock |
| cpu_reset | output | 1 | Active-high reset to the main CPU |
| boot_error | output | 1 | Source stalled past the limit |

## Verification
The bench builds the block with IMAGE_LEN=8, START_ADDR=16'hFFF8 and SETTLE_CYCLES=3. A whole copy therefore fits in a few dozen cycles and ends at the last address of the map. It also makes the settle count differ from the two-cycle minimum, so an off-by-one in the release delay shows up. STALL_W=8 with a limit of 6 lets the bench place gaps just below the limit during the copy, then hit the exact edge where the error rises. A second reset and a zero limit exercise the disabled timeout.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_COPY,
    ST_SWITCH,
    ST_RUN,
    ST_FAULT
  } boot_state_t;
endpackage

// File: rtl/boot_addr_ctr.sv
module boot_addr_ctr #(
  parameter int ADDR_W     = 16,
  parameter int IMAGE_LEN  = 16384,
  parameter int START_ADDR = 16'hC000,
  localparam int CNT_W     = $clog2(IMAGE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_inc
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end

  assign cur_addr = ADDR_W'(START_ADDR) + ADDR_W'(count);
  assign last_inc = inc && (count == CNT_W'(IMAGE_LEN - 1));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    inc |-> (count < CNT_W'(IMAGE_LEN)));
endmodule

// File: rtl/boot_stall_timer.sv
module boot_stall_timer #(
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               waiting,
  input  logic [STALL_W-1:0] limit,
  output logic               expire
);
  logic [STALL_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst || !waiting) wait_cnt <= '0;
    else if (!expire)    wait_cnt <= wait_cnt + STALL_W'(1);
  end

  assign expire = waiting && (limit != '0) && (wait_cnt == limit - STALL_W'(1));

  assert_clear_on_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !waiting |=> (wait_cnt == '0));
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_copy_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SETTLE_CYCLES = 2,
  localparam int SET_W        = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic [7:0]        src_data,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              last_inc,
  input  logic              expire,
  output logic              inc,
  output logic              waiting,
  output logic              src_ready,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [7:0]        sram_wdata,
  output logic              sram_we_n,
  output logic              clk_fast_sel,
  output logic              cpu_reset,
  output logic              boot_error
);
  boot_state_t      state;
  logic [SET_W-1:0] settle;
  logic             accept;

  assign accept  = (state == ST_COPY) && sram_we_n && src_ready && src_valid;
  assign inc     = (state == ST_COPY) && !sram_we_n;
  assign waiting = (state == ST_COPY) && sram_we_n && src_ready && !src_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_HOLD;
      src_ready    <= 1'b0;
      sram_addr    <= '0;
      sram_wdata   <= '0;
      sram_we_n    <= 1'b1;
      clk_fast_sel <= 1'b0;
      cpu_reset    <= 1'b1;
      boot_error   <= 1'b0;
      settle       <= '0;
    end else begin
      case (state)
        ST_HOLD: begin
          state     <= ST_COPY;
          src_ready <= 1'b1;
        end
        ST_COPY: begin
          if (!sram_we_n) begin
            sram_we_n <= 1'b1;
            if (last_inc) begin
              state     <= ST_SWITCH;
              src_ready <= 1'b0;
            end else begin
              src_ready <= 1'b1;
            end
          end else if (accept) begin
            sram_addr  <= cur_addr;
            sram_wdata <= src_data;
            sram_we_n  <= 1'b0;
            src_ready  <= 1'b0;
          end else if (expire) begin
            state      <= ST_FAULT;
            boot_error <= 1'b1;
            src_ready  <= 1'b0;
          end
        end
        ST_SWITCH: begin
          if (!clk_fast_sel) begin
            clk_fast_sel <= 1'b1;
            settle       <= '0;
          end else if (settle == SET_W'(SETTLE_CYCLES - 1)) begin
            state     <= ST_RUN;
            cpu_reset <= 1'b0;
          end else begin
            settle <= settle + SET_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assert_strobe_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |=> sram_we_n);
  assert_strobe_stable_R4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |=> ($stable(sram_addr) && $stable(sram_wdata)));
  assert_no_ready_in_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !src_ready);
  assert_reset_outside_run_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN) |-> cpu_reset);
  assert_switch_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_fast_sel) |-> ($past(state) == ST_SWITCH));
  assert_fast_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    clk_fast_sel |=> clk_fast_sel);
  assert_fault_holds_R9: assert property (@(posedge clk) disable iff (rst)
    boot_error |-> (cpu_reset && !clk_fast_sel && sram_we_n && !src_ready));
endmodule

// File: rtl/boot_copy_ctrl.sv
module boot_copy_ctrl #(
  parameter int ADDR_W        = 16,
  parameter int IMAGE_LEN     = 16384,
  parameter int START_ADDR    = 16'hC000,
  parameter int SETTLE_CYCLES = 2,
  parameter int STALL_W       = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STALL_W-1:0] stall_limit,
  input  logic               src_valid,
  input  logic [7:0]         src_data,
  output logic               src_ready,
  output logic [ADDR_W-1:0]  sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               sram_we_n,
  output logic               clk_fast_sel,
  output logic               cpu_reset,
  output logic               boot_error
);
  logic [ADDR_W-1:0] cur_addr;
  logic              inc, last_inc, waiting, expire;

  boot_addr_ctr #(
    .ADDR_W(ADDR_W), .IMAGE_LEN(IMAGE_LEN), .START_ADDR(START_ADDR)
  ) i_ctr (
    .clk(clk), .rst(rst), .inc(inc), .cur_addr(cur_addr), .last_inc(last_inc)
  );

  boot_stall_timer #(.STALL_W(STALL_W)) i_tmo (
    .clk(clk), .rst(rst), .waiting(waiting), .limit(stall_limit), .expire(expire)
  );

  boot_seq_fsm #(.ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE_CYCLES)) i_fsm (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_data(src_data),
    .cur_addr(cur_addr), .last_inc(last_inc), .expire(expire), .inc(inc),
    .waiting(waiting), .src_ready(src_ready), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_we_n(sram_we_n), .clk_fast_sel(clk_fast_sel),
    .cpu_reset(cpu_reset), .boot_error(boot_error)
  );
endmodule

// File: tb/test_boot_copy_ctrl.sv
module test_boot_copy_ctrl;
  localparam int ADDR_W = 16;
  localparam int LEN    = 8;
  localparam int START  = 16'hFFF8;
  localparam int SETTLE = 3;
  localparam int SW     = 8;
  localparam int LIMIT  = 6;

  // each entry: {gap before the byte, byte value}
  localparam logic [15:0] VEC [LEN] = '{
    16'h00_A5, 16'h03_3C, 16'h05_00, 16'h00_FF,
    16'h02_5A, 16'h05_81, 16'h01_7E, 16'h00_C3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] stall_limit = SW'(LIMIT);
  logic src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic src_ready, sram_we_n, clk_fast_sel, cpu_reset, boot_error;
  logic [ADDR_W-1:0] sram_addr;
  logic [7:0] sram_wdata;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boot_copy_ctrl #(
    .ADDR_W(ADDR_W), .IMAGE_LEN(LEN), .START_ADDR(START),
    .SETTLE_CYCLES(SETTLE), .STALL_W(SW)
  ) i_boot_copy_ctrl (
    .clk(clk), .rst(rst), .stall_limit(stall_limit), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_we_n(sram_we_n), .clk_fast_sel(clk_fast_sel),
    .cpu_reset(cpu_reset), .boot_error(boot_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; src_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(cpu_reset && !clk_fast_sel && sram_we_n && !src_ready && !boot_error,
          "R1 reset outputs", {cpu_reset, clk_fast_sel, sram_we_n, src_ready, boot_error}, 5'b10100);
    rst = 1'b0;
  endtask

  // send one byte after a gap and check the write it produces
  task automatic send_byte(input int gap, input logic [7:0] d, input int idx);
    repeat (gap) @(negedge clk);
    src_valid = 1'b1; src_data = d;
    while (!src_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    src_valid = 1'b0;
    check(!sram_we_n, "R4 strobe low after accept", sram_we_n, 0);
    check(sram_addr == ADDR_W'(START + idx), "R3 address", sram_addr, START + idx);
    check(sram_wdata == d, "R3 data", sram_wdata, d);
    check(!src_ready, "R2 ready drops in strobe", src_ready, 0);
    check(cpu_reset, "R8 cpu held during copy", cpu_reset, 1);
    check(!boot_error, "R10 no error for short gaps", boot_error, 0);
  endtask

  initial begin
    int n;
    // phase 1: full copy walked from the vector table
    @(negedge clk);
    check(cpu_reset && sram_we_n && !clk_fast_sel, "R1 in reset", cpu_reset, 1);
    do_reset();
    @(negedge clk);
    check(src_ready && cpu_reset, "R1 ready after reset", src_ready, 1);
    for (int i = 0; i < LEN; i++) begin
      send_byte(int'(VEC[i][15:8]), VEC[i][7:0], i);
    end
    @(negedge clk);
    check(sram_we_n, "R4 strobe one cycle", sram_we_n, 1);
    check(!clk_fast_sel, "R6 not fast yet", clk_fast_sel, 0);
    @(negedge clk);
    check(clk_fast_sel, "R6 fast two cycles after final strobe", clk_fast_sel, 1);
    n = 0;
    while (cpu_reset && n < 20) begin @(negedge clk); n++; end
    check(n == SETTLE, "R7 settle cycles", n, SETTLE);
    check(clk_fast_sel && !boot_error, "R6 fast held in run", clk_fast_sel, 1);
    src_valid = 1'b1; src_data = 8'h11;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(sram_we_n && !src_ready, "R5 no write after image", {sram_we_n, src_ready}, 2'b10);
    end
    src_valid = 1'b0;

    // phase 2: timeout at the exact limit
    do_reset();
    send_byte(0, 8'h12, 0);
    send_byte(2, 8'h34, 1);
    @(negedge clk);
    repeat (LIMIT - 1) @(negedge clk);
    check(!boot_error, "R9 no error one cycle before limit", boot_error, 0);
    @(negedge clk);
    check(boot_error, "R9 error at limit", boot_error, 1);
    check(cpu_reset && !clk_fast_sel && !src_ready, "R9 held after error",
          {cpu_reset, clk_fast_sel, src_ready}, 3'b100);
    src_valid = 1'b1; src_data = 8'h99;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(sram_we_n && cpu_reset, "R9 no write after error", sram_we_n, 1);
    end
    src_valid = 1'b0;

    // phase 3: zero limit disables the timeout
    stall_limit = '0;
    do_reset();
    repeat (40) @(negedge clk);
    check(!boot_error && src_ready, "R10 zero limit no error", boot_error, 0);
    send_byte(0, 8'h6B, 0);
    check(!clk_fast_sel, "R8 still slow mid copy", clk_fast_sel, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule